// File: doc/BRIEF.md
# Post-PLL Clock Divider and Output Selector

This block sits behind an external PLL and builds two output clocks from two incoming clock levels: a reference clock and a VCO-rate clock. Both incoming clocks are sampled by a faster system clock, and everything inside runs on that clock. Each rising edge of a source is detected and used as a count step.

The main output can be driven from three places:
- the VCO divided by 2*P;
- the reference passed through undivided;
- the reference divided by 2*P.

P is a 5-bit post-divide value. The secondary output has four choices of its own, two of which are taken from the main output.

Three inputs act on the outputs, and each is inactive when it reads 1:
- **Output enable** gates only the main output.
- **Active-low power-down** turns both outputs off and freezes the divider.
- **Frequency select** picks one of two stored configuration sets.

Each output is delivered as a data bit plus a drive-enable bit, so a pad outside the block can float it. Configuration bits choose whether a disabled output floats or is driven low.

Top module: `pll_out_divsel`

## Requirements
- R1: With main source VCO/2P or reference/2P, the main output period is 2*Pe rising edges of the source and the high phase lasts Pe edges, where Pe = P and P = 0 counts as 1.
- R2: Main source encoding: 0 = VCO/(2*Pe), 1 = reference undivided, 2 = reference/(2*Pe), 3 = same as 0.
- R3: Secondary source encoding: 0 = reference, 1 = reference/2, 2 = main output before enable gating, 3 = that main output divided by 2.
- R4: With oe_in = 0 the main output stops (data 0) from its next low phase on, while the secondary output keeps toggling with its configured period.
- R5: When pdn_in = 0, one cycle later both data outputs are 0 and the divider count is held at zero. After pdn_in returns to 1, a divided main output starts low and then runs at its configured period.
- R6: An output disabled by output enable has main_en = NOT oe_hiz. Outputs disabled by power-down have their enables = NOT pd_hiz. The data bit is 0 in both cases.
- R7: fsel_in = 1 selects configuration set A and fsel_in = 0 selects set B; flipping fsel_in while running changes the output period to that of the new set.
- R8: The active set and the main gate change only while both raw outputs are low, so no pulse on the main output is shorter than the shorter half-period of the two sets.
- R9: While reset is asserted, both data outputs are 0 and both drive enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than both sampled clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock level |
| vco_in | input | 1 | VCO-rate clock level |
| oe_in | input | 1 | Main output enable, 1 = run |
| pdn_in | input | 1 | Power-down, 0 = sleep |
| fsel_in | input | 1 | Set select, 1 = set A, 0 = set B |
| cfg_a_p | input | P_WIDTH | Set A post-divide value |
| cfg_a_msrc | input | 2 | Set A main source (R2) |
| cfg_a_ssrc | input | 2 | Set A secondary source (R3) |
| cfg_b_p | input | P_WIDTH | Set B post-divide value |
| cfg_b_msrc | input | 2 | Set B main source |
| cfg_b_ssrc | input | 2 | Set B secondary source |
| oe_hiz | input | 1 | 1 = float main output when output enable is off |
| pd_hiz | input | 1 | 1 = float both outputs in power-down |
| main_dat | output | 1 | Main output data |
| main_en | output | 1 | Main output drive enable |
| sec_dat | output | 1 | Secondary output data |
| sec_en | output | 1 | Secondary output drive enable |

## Verification
The hardest situation to reach is a set switch or an enable change landing in the middle of a high phase. That is the only place a runt pulse could appear, and it depends on how the set-select or enable flip lines up with the divider phase.

The stimulus runs two divided sets with different half-periods. It flips the set-select and enable inputs at random cycle counts, so many flips land in high phases. A pulse-width tracker on the main output records the shortest high and low phases across the whole window.

// File: rtl/pods_pkg.sv
`timescale 1ns/1ps
package pods_pkg;
  localparam int P_W_DEF = 5;

  typedef enum logic [1:0] {
    MSRC_VCO_DIV = 2'd0,
    MSRC_REF     = 2'd1,
    MSRC_REF_DIV = 2'd2,
    MSRC_VCO_ALT = 2'd3
  } msrc_e;

  typedef enum logic [1:0] {
    SSRC_REF       = 2'd0,
    SSRC_REF_HALF  = 2'd1,
    SSRC_MAIN      = 2'd2,
    SSRC_MAIN_HALF = 2'd3
  } ssrc_e;
endpackage

// File: rtl/pods_post_div.sv
`timescale 1ns/1ps
module pods_post_div #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [PW-1:0] p,
  output logic          q,
  output logic [PW-1:0] cnt
);
  logic [PW-1:0] lim;
  logic [PW-1:0] cnt_nxt;
  logic          q_nxt;

  // zero post-divide behaves as one
  assign lim = (p == '0) ? '0 : p - 1'b1;

  always_comb begin
    cnt_nxt = cnt;
    q_nxt   = q;
    if (clr) begin
      cnt_nxt = '0;
      q_nxt   = 1'b0;
    end else if (step) begin
      if (cnt >= lim) begin
        cnt_nxt = '0;
        q_nxt   = ~q;
      end else begin
        cnt_nxt = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      q   <= q_nxt;
    end
  end
endmodule

// File: rtl/pods_sec_path.sv
`timescale 1ns/1ps
module pods_sec_path (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            ref_lvl,
  input  logic            ref_rise,
  input  logic            main_lvl,
  input  pods_pkg::ssrc_e ssrc,
  output logic            sec_lvl
);
  import pods_pkg::*;

  logic main_q, main_q_nxt;
  logic ref_half, ref_half_nxt;
  logic main_half, main_half_nxt;
  logic main_rise;

  assign main_rise = main_lvl & ~main_q;

  always_comb begin
    main_q_nxt    = main_lvl;
    ref_half_nxt  = ref_half;
    main_half_nxt = main_half;
    if (clr) begin
      ref_half_nxt  = 1'b0;
      main_half_nxt = 1'b0;
    end else begin
      if (ref_rise)  ref_half_nxt  = ~ref_half;
      if (main_rise) main_half_nxt = ~main_half;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q    <= 1'b0;
      ref_half  <= 1'b0;
      main_half <= 1'b0;
    end else begin
      main_q    <= main_q_nxt;
      ref_half  <= ref_half_nxt;
      main_half <= main_half_nxt;
    end
  end

  always_comb begin
    case (ssrc)
      SSRC_REF:       sec_lvl = ref_lvl;
      SSRC_REF_HALF:  sec_lvl = ref_half;
      SSRC_MAIN:      sec_lvl = main_lvl;
      SSRC_MAIN_HALF: sec_lvl = main_half;
      default:        sec_lvl = 1'b0;
    endcase
  end
endmodule

// File: rtl/pods_out_stage.sv
`timescale 1ns/1ps
module pods_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic gate,
  input  logic run,
  input  logic gate_hiz,
  input  logic pd_hiz,
  output logic dat,
  output logic en
);
  logic dat_nxt, en_nxt;

  always_comb begin
    if (!run) begin
      dat_nxt = 1'b0;
      en_nxt  = ~pd_hiz;
    end else if (!gate) begin
      dat_nxt = 1'b0;
      en_nxt  = ~gate_hiz;
    end else begin
      dat_nxt = raw;
      en_nxt  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat <= 1'b0;
      en  <= 1'b1;
    end else begin
      dat <= dat_nxt;
      en  <= en_nxt;
    end
  end
endmodule

// File: rtl/pll_out_divsel.sv
`timescale 1ns/1ps
module pll_out_divsel #(
  parameter int P_WIDTH = pods_pkg::P_W_DEF,
  parameter int N_OUT   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_in,
  input  logic               vco_in,
  input  logic               oe_in,
  input  logic               pdn_in,
  input  logic               fsel_in,
  input  logic [P_WIDTH-1:0] cfg_a_p,
  input  logic [1:0]         cfg_a_msrc,
  input  logic [1:0]         cfg_a_ssrc,
  input  logic [P_WIDTH-1:0] cfg_b_p,
  input  logic [1:0]         cfg_b_msrc,
  input  logic [1:0]         cfg_b_ssrc,
  input  logic               oe_hiz,
  input  logic               pd_hiz,
  output logic               main_dat,
  output logic               main_en,
  output logic               sec_dat,
  output logic               sec_en
);
  import pods_pkg::*;

  localparam int MAIN_IDX = 0;
  localparam int SEC_IDX  = N_OUT - 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic ref_q, vco_q, act_b, oe_act;
  logic act_b_nxt, oe_act_nxt, ctl_ce;
  logic ref_rise, vco_rise;
  logic [P_WIDTH-1:0] p_act;
  msrc_e msrc_act;
  ssrc_e ssrc_act;
  logic div_q, div_step, main_raw, sec_raw, low_phase;
  logic [P_WIDTH-1:0] div_cnt;

  assign ref_rise = ref_in & ~ref_q;
  assign vco_rise = vco_in & ~vco_q;

  assign p_act    = act_b ? cfg_b_p : cfg_a_p;
  assign msrc_act = msrc_e'(act_b ? cfg_b_msrc : cfg_a_msrc);
  assign ssrc_act = ssrc_e'(act_b ? cfg_b_ssrc : cfg_a_ssrc);

  assign div_step = (msrc_act == MSRC_REF_DIV) ? ref_rise : vco_rise;
  assign main_raw = (msrc_act == MSRC_REF) ? ref_q : div_q;

  pods_post_div #(.PW(P_WIDTH)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (~pdn_in),
    .step  (div_step),
    .p     (p_act),
    .q     (div_q),
    .cnt   (div_cnt)
  );

  pods_sec_path u_sec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (~pdn_in),
    .ref_lvl  (ref_q),
    .ref_rise (ref_rise),
    .main_lvl (main_raw),
    .ssrc     (ssrc_act),
    .sec_lvl  (sec_raw)
  );

  // set and gate follow their inputs only in a common low phase
  assign low_phase  = ~main_raw & ~sec_raw;
  assign ctl_ce     = low_phase | ~pdn_in;
  assign act_b_nxt  = ctl_ce ? ~fsel_in : act_b;
  assign oe_act_nxt = ctl_ce ? oe_in : oe_act;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ref_q  <= 1'b0;
      vco_q  <= 1'b0;
      act_b  <= 1'b0;
      oe_act <= 1'b1;
    end else begin
      ref_q  <= ref_in;
      vco_q  <= vco_in;
      act_b  <= act_b_nxt;
      oe_act <= oe_act_nxt;
    end
  end

  logic [N_OUT-1:0] raw_v, gate_v, hiz_v, dat_v, en_v;
  assign raw_v[MAIN_IDX]  = main_raw;
  assign gate_v[MAIN_IDX] = oe_act;
  assign hiz_v[MAIN_IDX]  = oe_hiz;
  assign raw_v[SEC_IDX]   = sec_raw;
  assign gate_v[SEC_IDX]  = 1'b1;
  assign hiz_v[SEC_IDX]   = 1'b0;

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    pods_out_stage u_stage (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .raw      (raw_v[k]),
      .gate     (gate_v[k]),
      .run      (pdn_in),
      .gate_hiz (hiz_v[k]),
      .pd_hiz   (pd_hiz),
      .dat      (dat_v[k]),
      .en       (en_v[k])
    );
  end

  assign main_dat = dat_v[MAIN_IDX];
  assign main_en  = en_v[MAIN_IDX];
  assign sec_dat  = dat_v[SEC_IDX];
  assign sec_en   = en_v[SEC_IDX];
endmodule

// File: rtl/pods_chk.sv
`timescale 1ns/1ps
module pods_chk #(
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pdn_in,
  input logic          pd_hiz,
  input logic          main_dat,
  input logic          main_en,
  input logic          sec_dat,
  input logic          sec_en,
  input logic          act_b,
  input logic [PW-1:0] div_cnt
);
  assert_pd_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_in |=> (!main_dat && !sec_dat));

  assert_pd_hold_cnt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_in |=> (div_cnt == '0));

  assert_pd_style_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_in |=> ((main_en == !$past(pd_hiz)) && (sec_en == !$past(pd_hiz))));

  assert_sec_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_in |=> sec_en);

  assert_switch_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_b) |-> (!main_dat && !sec_dat));
endmodule

bind pll_out_divsel pods_chk #(.PW(P_WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .pdn_in   (pdn_in),
  .pd_hiz   (pd_hiz),
  .main_dat (main_dat),
  .main_en  (main_en),
  .sec_dat  (sec_dat),
  .sec_en   (sec_en),
  .act_b    (act_b),
  .div_cnt  (div_cnt)
);

// File: tb/pll_out_divsel_bench.sv
`timescale 1ns/1ps
module pll_out_divsel_bench;
  localparam int PW = 5;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_in = 1'b0, vco_in = 1'b0;
  logic oe_in, pdn_in, fsel_in, oe_hiz, pd_hiz;
  logic [PW-1:0] cfg_a_p, cfg_b_p;
  logic [1:0] cfg_a_msrc, cfg_a_ssrc, cfg_b_msrc, cfg_b_ssrc;
  logic main_dat, main_en, sec_dat, sec_en;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  int ref_half = 2, vco_half = 1;
  int rc = 0, vc = 0;

  always #2.5 clk = ~clk;

  pll_out_divsel u_pll_out_divsel (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in),
    .oe_in(oe_in), .pdn_in(pdn_in), .fsel_in(fsel_in),
    .cfg_a_p(cfg_a_p), .cfg_a_msrc(cfg_a_msrc), .cfg_a_ssrc(cfg_a_ssrc),
    .cfg_b_p(cfg_b_p), .cfg_b_msrc(cfg_b_msrc), .cfg_b_ssrc(cfg_b_ssrc),
    .oe_hiz(oe_hiz), .pd_hiz(pd_hiz),
    .main_dat(main_dat), .main_en(main_en), .sec_dat(sec_dat), .sec_en(sec_en)
  );

  // source clocks, driven away from the active edge
  always @(negedge clk) begin
    if (rc >= ref_half - 1) begin rc = 0; ref_in = ~ref_in; end else rc++;
    if (vc >= vco_half - 1) begin vc = 0; vco_in = ~vco_in; end else vc++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected under %0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // main output pulse-width tracker
  logic trk_on = 1'b0, trk_prev = 1'b0;
  int trk_edges = 0, trk_run = 0, min_hi = 1 << 30, min_lo = 1 << 30;
  always @(negedge clk) begin
    if (!trk_on) begin
      trk_edges = 0; trk_run = 0; min_hi = 1 << 30; min_lo = 1 << 30;
      trk_prev = main_dat;
    end else begin
      if (main_dat != trk_prev) begin
        if (trk_edges >= 1) begin
          if (trk_prev && trk_run < min_hi) min_hi = trk_run;
          if (!trk_prev && trk_run < min_lo) min_lo = trk_run;
        end
        trk_edges++;
        trk_run = 1;
      end else trk_run++;
      trk_prev = main_dat;
    end
  end

  function automatic int pe(int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic int exp_main(int p, int ms);
    case (ms)
      1: return 2 * ref_half;
      2: return 4 * pe(p) * ref_half;
      default: return 4 * pe(p) * vco_half;
    endcase
  endfunction

  function automatic int exp_main_hi(int p, int ms);
    return (ms == 1) ? ref_half : exp_main(p, ms) / 2;
  endfunction

  function automatic int exp_sec(int ss, int mp);
    case (ss)
      0: return 2 * ref_half;
      1: return 4 * ref_half;
      2: return mp;
      default: return 2 * mp;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic pick(int which);
    return (which == 0) ? main_dat : sec_dat;
  endfunction

  // period and high width between the 2nd and 3rd rising edges
  task automatic measure(input int which, output int per, output int hi);
    int t_r1 = 0, t_f = 0, t_r2 = 0, state = 0, guard = 0;
    logic prev, cur;
    prev = pick(which);
    while (state < 4 && guard < 20000) begin
      @(negedge clk);
      guard++;
      cur = pick(which);
      if (cur && !prev) begin
        if (state == 0) state = 1;
        else if (state == 1) begin t_r1 = cyc; state = 2; end
        else if (state == 3) begin t_r2 = cyc; state = 4; end
      end
      if (!cur && prev && state == 2) begin t_f = cyc; state = 3; end
      prev = cur;
    end
    if (state < 4) begin per = -1; hi = -1; end
    else begin per = t_r2 - t_r1; hi = t_f - t_r1; end
  endtask

  task automatic setup_a(input int p, input int ms, input int ss);
    @(negedge clk);
    pdn_in = 1'b0;
    repeat (3) @(negedge clk);
    cfg_a_p = PW'(p); cfg_a_msrc = 2'(ms); cfg_a_ssrc = 2'(ss);
    fsel_in = 1'b1;
    pdn_in = 1'b1;
  endtask

  task automatic run_case(input int p, input int ms, input int ss, input string req);
    int per, hi, mp;
    setup_a(p, ms, ss);
    mp = exp_main(p, ms);
    measure(0, per, hi);
    chk(per == mp, {req, " main period"}, per, mp);
    chk(hi == exp_main_hi(p, ms), {req, " main high"}, hi, exp_main_hi(p, ms));
    measure(1, per, hi);
    chk(per == exp_sec(ss, mp), {req, " R3 sec period"}, per, exp_sec(ss, mp));
  endtask

  initial begin
    int per, hi, highs, bad;
    void'($urandom(20240611));
    rst_n = 1'b0;
    oe_in = 1'b1; pdn_in = 1'b1; fsel_in = 1'b1; oe_hiz = 1'b0; pd_hiz = 1'b0;
    cfg_a_p = 5'd2; cfg_a_msrc = 2'd0; cfg_a_ssrc = 2'd0;
    cfg_b_p = 5'd4; cfg_b_msrc = 2'd0; cfg_b_ssrc = 2'd0;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(!main_dat && !sec_dat, "R9 data in reset", {main_dat, sec_dat}, 0);
    chk(main_en && sec_en, "R9 enable in reset", {main_en, sec_en}, 3);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 divider: P=0 behaves as P=1, full range
    ref_half = 2; vco_half = 1;
    run_case(0, 0, 0, "R1 P=0");
    run_case(1, 0, 1, "R1 P=1");
    run_case(31, 0, 2, "R1 P=31");
    vco_half = 2;
    run_case(5, 0, 3, "R1 P=5");
    // R2 source encodings
    run_case(3, 1, 0, "R2 ref undivided");
    run_case(3, 2, 2, "R2 ref div");
    run_case(3, 3, 3, "R2 alt code");

    // random mix
    for (int i = 0; i < 10; i++) begin
      ref_half = $urandom_range(1, 3);
      vco_half = $urandom_range(1, 3);
      run_case($urandom_range(0, 31), $urandom_range(0, 3), $urandom_range(0, 3), "R1/R2 random");
    end

    // R4/R6 output enable off, secondary taken from main
    ref_half = 2; vco_half = 1;
    for (int hz = 0; hz < 2; hz++) begin
      setup_a(2, 0, 2);
      oe_hiz = hz[0];
      repeat (30) @(negedge clk);
      oe_in = 1'b0;
      repeat (30) @(negedge clk);
      highs = 0; bad = 0;
      for (int c = 0; c < 100; c++) begin
        @(negedge clk);
        if (main_dat) highs++;
        if (main_en != !oe_hiz) bad++;
      end
      chk(highs == 0, "R4 main held low with OE off", highs, 0);
      chk(bad == 0, "R6 main drive style with OE off", bad, 0);
      measure(1, per, hi);
      chk(per == exp_main(2, 0), "R4 sec keeps running", per, exp_main(2, 0));
      oe_in = 1'b1;
      measure(0, per, hi);
      chk(per == exp_main(2, 0), "R4 main resumes", per, exp_main(2, 0));
    end
    oe_hiz = 1'b0;

    // R5/R6 power-down
    for (int hz = 0; hz < 2; hz++) begin
      setup_a(4, 0, 1);
      pd_hiz = hz[0];
      repeat (40) @(negedge clk);
      pdn_in = 1'b0;
      repeat (2) @(negedge clk);
      highs = 0; bad = 0;
      for (int c = 0; c < 50; c++) begin
        @(negedge clk);
        if (main_dat || sec_dat) highs++;
        if (main_en != !pd_hiz || sec_en != !pd_hiz) bad++;
      end
      chk(highs == 0, "R5 outputs low in power-down", highs, 0);
      chk(bad == 0, "R6 power-down drive style", bad, 0);
      vco_half = 2;
      pdn_in = 1'b1;
      highs = 0;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        if (main_dat) highs++;
      end
      chk(highs == 0, "R5 main starts low after wake", highs, 0);
      measure(0, per, hi);
      chk(per == exp_main(4, 0), "R5 period after wake", per, exp_main(4, 0));
      vco_half = 1;
    end
    pd_hiz = 1'b0;

    // R7 set switch, R8 no runt pulses under random flips
    vco_half = 2;
    cfg_b_p = 5'd5; cfg_b_msrc = 2'd0; cfg_b_ssrc = 2'd2;
    setup_a(3, 0, 2);
    measure(0, per, hi);
    chk(per == exp_main(3, 0), "R7 set A period", per, exp_main(3, 0));
    fsel_in = 1'b0;
    measure(0, per, hi);
    chk(per == exp_main(5, 0), "R7 set B period", per, exp_main(5, 0));
    trk_on = 1'b1;
    for (int k = 0; k < 60; k++) begin
      repeat ($urandom_range(1, 40)) @(negedge clk);
      if ($urandom_range(0, 3) == 0) oe_in = ~oe_in;
      else fsel_in = ~fsel_in;
    end
    oe_in = 1'b1;
    repeat (200) @(negedge clk);
    trk_on = 1'b0;
    chk(min_hi >= 2 * pe(3) * vco_half, "R8 shortest high phase", min_hi, 2 * pe(3) * vco_half);
    chk(min_lo >= 2 * pe(3) * vco_half, "R8 shortest low phase", min_lo, 2 * pe(3) * vco_half);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule